// File: doc/BRIEF.md
# Vector Length Configuration Unit

This unit executes the three vector configuration instructions (the immediate-vtype form, the immediate-length form and the register-vtype form). It holds the architectural vector length, the vector type word and the vector start index. For each accepted request it works out the requested type word, checks that the type is legal, computes the largest element count the register group can hold (VLMAX), picks the new vector length, stores the new state and returns the length as the value to write to the destination register.

The hardware vector register width is a parameter. The byte count of a register is derived from it, and the width in bits is recomputed from that byte count, so the whole datapath is sized from one number. The maximum element width is also a parameter and defaults to 64. The current vector length and type are always visible on output ports so that a front end can use them.

A request is one cycle of `req_valid`. The result is registered and marked by a single-cycle `done` pulse. The unit reports `busy` during that pulse, and a request offered while busy is dropped.

Top module: `vcfg_unit`

## Requirements
- R1: After synchronous reset, `vl_o` is 0, `vtype_o` is 0x8000_0000_0000_0000 (only the illegal flag at bit 63 set), `vstart_o` is 0, and `done` and `busy` are 0.
- R2: A request accepted on a clock edge (`req_valid` high, `busy` low, `req_kind` not 3) gives `done` high for exactly the following cycle, with `busy` also high in that cycle. A request offered while `busy` is high is ignored and changes no state.
- R3: Every completed request leaves `vstart_o` at 0.
- R4: `req_kind` encodes the form: 0 takes the requested type from `imm_vtype[10:0]` and the length from `rs1_val`; 1 takes the type from `imm_vtype[9:0]` (bit 10 ignored) and the length from `imm_avl`; 2 takes the type from `rs2_val` and the length from `rs1_val`. Unused type bits are zero.
- R5: A requested type is illegal when its multiplier field is 100, its element-width field is above 011, any of bits 63..8 is set, or the element width exceeds min(LMUL,1) x ELEN. An illegal request stores a type of exactly bit 63 set and a length of 0.
- R6: Type fields: multiplier at bits [2:0] (000/001/010/011 = 1/2/4/8, 101/110/111 = 1/8, 1/4, 1/2), element width at bits [5:3] (000..011 = 8/16/32/64 bits), tail and mask policy flags at bits 6 and 7. VLMAX = (VLEN / SEW) x LMUL.
- R7: For a legal type, the new length is min(requested length, VLMAX).
- R8: In forms 0 and 2, if the rs1 index is 0 and the rd index is not 0, the length becomes VLMAX. If both indices are 0, the length becomes min(current length, VLMAX). Form 1 ignores the register indices.
- R9: `req_kind` 3 is not a request: it produces no `done` and leaves all state unchanged.
- R10: With `done`, `rd_data` equals the new length (zero-extended) and `rd_idx_o` equals the rd index of the request. If the requested type equals the held type, the held type and its VLMAX are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_kind | input | 2 | Instruction form (0 imm-vtype, 1 imm-length, 2 reg-vtype, 3 none) |
| req_rd | input | 5 | Destination register index |
| req_rs1 | input | 5 | Source register index for the length |
| rs1_val | input | XLEN | Requested length value |
| rs2_val | input | XLEN | Requested type for form 2 |
| imm_avl | input | 5 | Immediate length for form 1 |
| imm_vtype | input | 11 | Immediate type for forms 0 and 1 |
| busy | output | 1 | Unit cannot accept a request this cycle |
| done | output | 1 | Result valid pulse |
| rd_idx_o | output | 5 | Destination index of the completed request |
| rd_data | output | XLEN | Value to write to the destination register |
| vl_o | output | VLW | Current vector length |
| vtype_o | output | XLEN | Current vector type word |
| vstart_o | output | VLW | Current vector start index |

## Verification
Directed requests cover each multiplier and element-width pair at the edges of legality: fractional multipliers against element width, the reserved codes, and high reserved bits. These separate a correct legality check from one that ignores one of the rules. Length requests below, at and above VLMAX, together with the two x0 index patterns and the immediate form, separate correct clamping from a wrong choice of length source. Random forms, indices and type words, with a random bit 10 in the immediate of form 1, are checked against a bench model. A request held during `busy` and a kind-3 request check that nothing changes when the unit should do nothing.

// File: rtl/vcfg_pkg.sv
package vcfg_pkg;
  typedef enum logic [1:0] {
    K_VLI  = 2'd0,
    K_IVLI = 2'd1,
    K_VL   = 2'd2,
    K_NONE = 2'd3
  } cfg_kind_e;

  localparam int unsigned REG_IDX_W = 5;
  localparam int unsigned IMM_VT_W  = 11;
  localparam int unsigned IMM_AVL_W = 5;
endpackage

// File: rtl/vcfg_vtype_eval.sv
module vcfg_vtype_eval #(
  parameter int unsigned VLEN = 128,
  parameter int unsigned ELEN = 64,
  parameter int unsigned XLEN = 64,
  parameter int unsigned VLW  = 8
) (
  input  logic [2:0]      lmul,
  input  logic [2:0]      sew,
  input  logic [XLEN-9:0] resv,
  output logic            illegal,
  output logic [VLW-1:0]  vlmax
);
  logic [VLW-1:0] per_sew [4];
  for (genvar g = 0; g < 4; g++) begin : g_sew
    assign per_sew[g] = VLW'(VLEN >> (3 + g));
  end

  logic [1:0]     frac_sh;
  logic [1:0]     int_sh;
  logic [VLW+2:0] scaled;
  int unsigned    sew_bits;
  int unsigned    elen_lim;

  always_comb begin
    case (lmul)
      3'b101:  frac_sh = 2'd3;
      3'b110:  frac_sh = 2'd2;
      3'b111:  frac_sh = 2'd1;
      default: frac_sh = 2'd0;
    endcase
    int_sh   = lmul[2] ? 2'd0 : lmul[1:0];
    sew_bits = 32'd8 << sew[1:0];
    elen_lim = ELEN >> frac_sh;
    illegal  = (lmul == 3'b100) || sew[2] || (|resv) || (sew_bits > elen_lim);
    scaled   = ({3'b000, per_sew[sew[1:0]]} << int_sh) >> frac_sh;
    vlmax    = illegal ? '0 : scaled[VLW-1:0];
  end
endmodule

// File: rtl/vcfg_avl_pick.sv
module vcfg_avl_pick
  import vcfg_pkg::*;
#(
  parameter int unsigned XLEN = 64,
  parameter int unsigned VLW  = 8
) (
  input  cfg_kind_e               kind,
  input  logic [REG_IDX_W-1:0]    rd_idx,
  input  logic [REG_IDX_W-1:0]    rs1_idx,
  input  logic [XLEN-1:0]         rs1_val,
  input  logic [IMM_AVL_W-1:0]    imm_avl,
  input  logic [VLW-1:0]          cur_vl,
  input  logic [VLW-1:0]          vlmax,
  output logic [VLW-1:0]          new_vl
);
  logic [XLEN-1:0] avl;

  always_comb begin
    if (kind == K_IVLI)        avl = XLEN'(imm_avl);
    else if (rs1_idx != '0)    avl = rs1_val;
    else if (rd_idx != '0)     avl = '1;
    else                       avl = XLEN'(cur_vl);

    if (vlmax == '0)                new_vl = '0;
    else if (avl > XLEN'(vlmax))    new_vl = vlmax;
    else                            new_vl = avl[VLW-1:0];
  end
endmodule

// File: rtl/vcfg_unit.sv
module vcfg_unit
  import vcfg_pkg::*;
#(
  parameter int unsigned XLEN = 64,
  parameter int unsigned VLEN = 128,
  parameter int unsigned ELEN = 64,
  localparam int unsigned VLENB     = VLEN / 8,
  localparam int unsigned VLEN_BITS = VLENB * 8,
  localparam int unsigned VLW       = $clog2(VLEN_BITS + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  input  logic [1:0]            req_kind,
  input  logic [4:0]            req_rd,
  input  logic [4:0]            req_rs1,
  input  logic [XLEN-1:0]       rs1_val,
  input  logic [XLEN-1:0]       rs2_val,
  input  logic [4:0]            imm_avl,
  input  logic [10:0]           imm_vtype,
  output logic                  busy,
  output logic                  done,
  output logic [4:0]            rd_idx_o,
  output logic [XLEN-1:0]       rd_data,
  output logic [VLW-1:0]        vl_o,
  output logic [XLEN-1:0]       vtype_o,
  output logic [VLW-1:0]        vstart_o
);
  localparam logic [XLEN-1:0] VILL_ONLY = {1'b1, {(XLEN-1){1'b0}}};

  cfg_kind_e       kind;
  logic            accept;
  logic [XLEN-1:0] req_vtype;
  logic            same_vt;
  logic            ev_illegal;
  logic [VLW-1:0]  ev_vlmax;
  logic [XLEN-1:0] nxt_vtype;
  logic [VLW-1:0]  nxt_vlmax;
  logic [VLW-1:0]  nxt_vl;

  logic            done_q;
  logic [VLW-1:0]  vl_q;
  logic [VLW-1:0]  vlmax_q;
  logic [XLEN-1:0] vtype_q;
  logic [VLW-1:0]  vstart_q;
  logic [XLEN-1:0] rd_data_q;
  logic [4:0]      rd_idx_q;

  assign kind   = cfg_kind_e'(req_kind);
  assign accept = req_valid && !done_q && (kind != K_NONE);

  always_comb begin
    case (kind)
      K_VLI:   req_vtype = XLEN'(imm_vtype);
      K_IVLI:  req_vtype = XLEN'(imm_vtype[9:0]);
      default: req_vtype = rs2_val;
    endcase
  end

  vcfg_vtype_eval #(
    .VLEN(VLEN_BITS), .ELEN(ELEN), .XLEN(XLEN), .VLW(VLW)
  ) u_eval (
    .lmul    (req_vtype[2:0]),
    .sew     (req_vtype[5:3]),
    .resv    (req_vtype[XLEN-1:8]),
    .illegal (ev_illegal),
    .vlmax   (ev_vlmax)
  );

  // Reuse held type and VLMAX when the request repeats it.
  assign same_vt   = (req_vtype == vtype_q);
  assign nxt_vtype = same_vt ? vtype_q : (ev_illegal ? VILL_ONLY : req_vtype);
  assign nxt_vlmax = same_vt ? vlmax_q : ev_vlmax;

  vcfg_avl_pick #(.XLEN(XLEN), .VLW(VLW)) u_pick (
    .kind    (kind),
    .rd_idx  (req_rd),
    .rs1_idx (req_rs1),
    .rs1_val (rs1_val),
    .imm_avl (imm_avl),
    .cur_vl  (vl_q),
    .vlmax   (nxt_vlmax),
    .new_vl  (nxt_vl)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q    <= 1'b0;
      vl_q      <= '0;
      vlmax_q   <= '0;
      vtype_q   <= VILL_ONLY;
      vstart_q  <= '0;
      rd_data_q <= '0;
      rd_idx_q  <= '0;
    end else begin
      done_q <= accept;
      if (accept) begin
        vl_q      <= nxt_vl;
        vlmax_q   <= nxt_vlmax;
        vtype_q   <= nxt_vtype;
        vstart_q  <= '0;
        rd_data_q <= XLEN'(nxt_vl);
        rd_idx_q  <= req_rd;
      end
    end
  end

  assign busy     = done_q;
  assign done     = done_q;
  assign rd_idx_o = rd_idx_q;
  assign rd_data  = rd_data_q;
  assign vl_o     = vl_q;
  assign vtype_o  = vtype_q;
  assign vstart_o = vstart_q;

  assert_done_single_R2: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_accept_done_R2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !busy && req_kind != 2'd3) |=> done);
  assert_idle_stable_R9: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && !busy && req_kind != 2'd3) |=> ($stable(vl_o) && $stable(vtype_o)));
  assert_illegal_store_R5: assert property (@(posedge clk) disable iff (rst)
    (accept && !same_vt && ev_illegal) |=> (vtype_o == VILL_ONLY && vl_o == '0));
  assert_vl_bound_R7: assert property (@(posedge clk) disable iff (rst)
    vl_o <= vlmax_q);
  assert_rd_result_R10: assert property (@(posedge clk) disable iff (rst)
    done |-> (rd_data == XLEN'(vl_o)));
endmodule

// File: tb/sim_vcfg_unit.sv
module sim_vcfg_unit;
  localparam int XLEN = 64;
  localparam int VLEN = 128;
  localparam int ELEN = 64;
  localparam int VLW  = $clog2(VLEN + 1);
  localparam logic [63:0] VILL = 64'h8000_0000_0000_0000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [1:0] req_kind = 2'd0;
  logic [4:0] req_rd = '0, req_rs1 = '0, imm_avl = '0;
  logic [63:0] rs1_val = '0, rs2_val = '0;
  logic [10:0] imm_vtype = '0;
  logic busy, done;
  logic [4:0] rd_idx_o;
  logic [63:0] rd_data, vtype_o;
  logic [VLW-1:0] vl_o, vstart_o;

  int checks = 0, fails = 0;
  bit finished = 0;
  longint unsigned m_vl = 0;
  logic [63:0] m_vt = VILL;

  always #5 clk = ~clk;

  vcfg_unit #(.XLEN(XLEN), .VLEN(VLEN), .ELEN(ELEN)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
    .req_rd(req_rd), .req_rs1(req_rs1), .rs1_val(rs1_val), .rs2_val(rs2_val),
    .imm_avl(imm_avl), .imm_vtype(imm_vtype), .busy(busy), .done(done),
    .rd_idx_o(rd_idx_o), .rd_data(rd_data), .vl_o(vl_o), .vtype_o(vtype_o),
    .vstart_o(vstart_o));

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // LMUL in eighths, 0 for the reserved code.
  function automatic int lmul8(input logic [2:0] c);
    case (c)
      3'b000: return 8;  3'b001: return 16; 3'b010: return 32; 3'b011: return 64;
      3'b101: return 1;  3'b110: return 2;  3'b111: return 4;
      default: return 0;
    endcase
  endfunction

  function automatic void model(input int kind, input logic [4:0] rd, input logic [4:0] rs1,
                                input logic [63:0] r1v, input logic [63:0] r2v,
                                input logic [4:0] ia, input logic [10:0] iv);
    logic [63:0] vt;
    longint unsigned vmax, avl;
    int l8, sb;
    bit bad;
    vt = (kind == 0) ? {53'd0, iv} : (kind == 1) ? {54'd0, iv[9:0]} : r2v;
    l8 = lmul8(vt[2:0]);
    sb = (vt[5:3] < 4) ? (8 << vt[5:3]) : 1024;
    bad = (l8 == 0) || (vt[5:3] > 3) || (vt[63:8] != 0) ||
          (sb * 8 > ((l8 < 8) ? l8 : 8) * ELEN);
    if (bad) begin m_vt = VILL; vmax = 0; end
    else begin m_vt = vt; vmax = longint'(VLEN) * l8 / (sb * 8); end
    if (kind == 1) avl = {59'd0, ia};
    else if (rs1 != 0) avl = r1v;
    else if (rd != 0) avl = 64'hFFFF_FFFF_FFFF_FFFF;
    else avl = m_vl;
    m_vl = (vmax == 0) ? 0 : ((avl > vmax) ? vmax : avl);
  endfunction

  task automatic apply(input int kind, input logic [4:0] rd, input logic [4:0] rs1,
                       input logic [63:0] r1v, input logic [63:0] r2v,
                       input logic [4:0] ia, input logic [10:0] iv, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_kind = 2'(kind); req_rd = rd; req_rs1 = rs1;
    rs1_val = r1v; rs2_val = r2v; imm_avl = ia; imm_vtype = iv;
    @(negedge clk);
    req_valid = 1'b0;
    model(kind, rd, rs1, r1v, r2v, ia, iv);
    chk(done === 1'b1 && busy === 1'b1, "R2 done/busy", {62'd0, done, busy}, 64'd3);
    chk(64'(vl_o) == m_vl, {tag, " vl"}, 64'(vl_o), m_vl);
    chk(vtype_o == m_vt, {tag, " vtype"}, vtype_o, m_vt);
    chk(rd_data == m_vl && rd_idx_o == rd, "R10 rd result", rd_data, m_vl);
    chk(vstart_o == 0, "R3 vstart", 64'(vstart_o), 64'd0);
    @(negedge clk);
    chk(done === 1'b0, "R2 done width", {63'd0, done}, 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(vl_o == 0 && vstart_o == 0 && !done && !busy, "R1 reset vl/flags", 64'(vl_o), 64'd0);
    chk(vtype_o == VILL, "R1 reset vtype", vtype_o, VILL);

    // R4/R7: e8 m1, avl 5
    apply(0, 5'd1, 5'd2, 64'd5, 64'd0, 5'd0, 11'h000, "R4 R7 e8m1 avl5");
    // R8/R6: rs1=x0 rd!=x0, e8 m8 -> VLMAX 128
    apply(0, 5'd3, 5'd0, 64'd7, 64'd0, 5'd0, 11'h003, "R8 R6 e8m8 max");
    // R5: e64 mf2 exceeds ELEN/2
    apply(0, 5'd4, 5'd2, 64'd9, 64'd0, 5'd0, 11'h01F, "R5 e64 mf2");
    // R5: reserved high bit
    apply(2, 5'd4, 5'd2, 64'd9, 64'h0010_0008, 5'd0, 11'h0, "R5 resv bit");
    // R5: reserved multiplier and width codes
    apply(2, 5'd4, 5'd2, 64'd9, 64'h04, 5'd0, 11'h0, "R5 lmul100");
    apply(2, 5'd4, 5'd2, 64'd9, 64'h20, 5'd0, 11'h0, "R5 sew100");
    // R5: requested vill bit
    apply(2, 5'd4, 5'd2, 64'd9, VILL | 64'h1, 5'd0, 11'h0, "R5 vill bit");
    // R6/R7: e32 m2 -> 8, avl 1000 clamps
    apply(2, 5'd6, 5'd7, 64'd1000, 64'h11, 5'd0, 11'h0, "R6 R7 e32m2 clamp");
    // R4/R8: immediate-length form, bit 10 ignored, x0 indices ignored; e8 mf8 -> 2
    apply(1, 5'd0, 5'd0, 64'd0, 64'd0, 5'd31, 11'h405, "R4 R8 ivli mf8");
    // R8 keep: set e32m2 avl 5, then both x0 keeps 5, then e64m1 clamps to 2
    apply(0, 5'd1, 5'd1, 64'd5, 64'd0, 5'd0, 11'h011, "R7 e32m2 avl5");
    apply(0, 5'd0, 5'd0, 64'd99, 64'd0, 5'd0, 11'h011, "R8 keep vl same vtype R10");
    apply(2, 5'd0, 5'd0, 64'd99, 64'h18, 5'd0, 11'h0, "R8 keep clamp e64m1");
    // R6: e16 m4 -> 32 with tail/mask flags
    apply(0, 5'd2, 5'd0, 64'd0, 64'd0, 5'd0, 11'h0CA, "R6 e16m4 flags");

    // R9: kind 3 ignored
    @(negedge clk);
    req_valid = 1'b1; req_kind = 2'd3; rs1_val = 64'd1; rs2_val = 64'h0; req_rs1 = 5'd1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!done && 64'(vl_o) == m_vl && vtype_o == m_vt, "R9 kind3 ignored", 64'(vl_o), m_vl);

    // R2: request held during busy is dropped
    @(negedge clk);
    req_valid = 1'b1; req_kind = 2'd0; req_rd = 5'd1; req_rs1 = 5'd1;
    rs1_val = 64'd3; imm_vtype = 11'h000;
    @(negedge clk);
    model(0, 5'd1, 5'd1, 64'd3, 64'd0, 5'd0, 11'h000);
    rs1_val = 64'd1; imm_vtype = 11'h003;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!done && 64'(vl_o) == m_vl && vtype_o == m_vt, "R2 busy request ignored", 64'(vl_o), m_vl);
    @(negedge clk);

    for (int i = 0; i < 400; i++) begin
      int k;
      logic [4:0] rd, rs1, ia;
      logic [63:0] r1v, r2v;
      logic [10:0] iv;
      k   = $urandom_range(0, 2);
      rd  = ($urandom_range(0, 3) == 0) ? 5'd0 : 5'($urandom);
      rs1 = ($urandom_range(0, 3) == 0) ? 5'd0 : 5'($urandom);
      r1v = ($urandom_range(0, 3) == 0) ? {$urandom, $urandom} : 64'($urandom_range(0, 200));
      r2v = {56'd0, 8'($urandom)};
      if ($urandom_range(0, 7) == 0) r2v[$urandom_range(8, 63)] = 1'b1;
      ia  = 5'($urandom);
      iv  = 11'($urandom);
      if ($urandom_range(0, 3) != 0) iv[10:8] = 3'd0;
      apply(k, rd, rs1, r1v, r2v, ia, iv, "R4 R5 R6 R7 R8 random");
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule